// File: doc/BRIEF.md
# Flash configuration and soft-reset unit

This unit sits beside the command sequencer of a serial flash model and owns its three configuration words. The 16-bit nonvolatile word holds settings that take effect at reset. The 8-bit volatile word and the 8-bit enhanced word hold the live settings. The unit also runs the two-step software reset. The sequencer passes it every byte of a chip-select frame. The first byte of a frame is the opcode. The unit decides whether the frame reads or writes one of the words, arms the reset, or fires the reset. It drives the read byte for the current slot and, on a soft reset, a one-cycle clear strobe back to the sequencer.

On a soft reset or a power-on reset, the unit rebuilds both volatile words from the nonvolatile word bit by bit. This happens only when the manufacturer-select parameter selects the configurable family. It also presents three values that the sequencer loads when it clears: the 4-byte-mode default, the extended-address default and the dummy count.

The frame state machine (`frame_st_t`) has these states:
- `ST_OPC`: waiting for the opcode.
- `ST_NV_LO` and `ST_NV_HI`: collecting the two nonvolatile bytes.
- `ST_V_WR` and `ST_EV_WR`: collecting the one-byte volatile or enhanced write.
- `ST_RD_NV_LO`, `ST_RD_NV_HI`, `ST_RD_V` and `ST_RD_EV`: presenting read bytes.
- `ST_SKIP`: ignoring the rest of the frame.

The transitions are:
- Raising `cs_n` returns the machine to `ST_OPC` from any state.
- In `ST_OPC`, an accepted opcode moves to its collect or read state. A write opcode moves to `ST_SKIP` when write-enable is low. Any other opcode moves to `ST_SKIP`.
- `ST_NV_LO` moves to `ST_NV_HI`, and `ST_RD_NV_LO` moves to `ST_RD_NV_HI`.
- Every last-byte state moves to `ST_SKIP`.
- `ST_SKIP` stays in `ST_SKIP`.

Top module: `cfgrst_unit`

## Requirements
- R1: Opcode 0x66 arms the reset. Any other opcode disarms it. Opcode 0x99 fires a soft reset only when the opcode accepted just before it was 0x66. The two opcodes may sit in separate frames.
- R2: A soft reset raises `seq_clear` for exactly one cycle, in the cycle after the 0x99 opcode byte is taken. `seq_clear` stays low for every other opcode.
- R3: On a soft reset with the configurable family selected, the volatile word becomes: bits 1:0 set, bit 2 clear, bit 3 set unless nonvolatile bits 11:9 are all ones, and bits 7:4 equal to nonvolatile bits 15:12.
- R4: On a soft reset with the configurable family selected, the enhanced word becomes: bits 2:0 equal to 7, bits 3 and 4 set, bit 5 clear, bit 6 equal to nonvolatile bit 2, and bit 7 equal to nonvolatile bit 3.
- R5: With the configurable family selected, `four_byte_dflt` is 1 exactly when nonvolatile bit 0 is clear. `ext_addr_dflt` is 3 when nonvolatile bit 1 is clear and 0 otherwise. `dummy_cnt` always equals volatile bits 7:4.
- R6: The nonvolatile word powers up to `NV_DEFAULT` (0x8FFF). Opcode 0xB1 followed by two bytes, low byte first, writes it. Opcode 0xB5 reads it, low byte then high byte. A nonvolatile write leaves the volatile and enhanced words unchanged until the next reset.
- R7: Opcode 0x81 writes one byte to the volatile word and 0x85 reads it. Opcode 0x61 writes one byte to the enhanced word and 0x65 reads it. Any write is ignored when `wr_enable` is low while the opcode byte is taken.
- R8: With any other manufacturer value, the volatile and enhanced words power up to 0 and are left unchanged by a soft reset. Both defaults then read 0.
- R9: Power-on reset gives the same derivation as a soft reset applied to `NV_DEFAULT`. For the default value this is volatile 0x83, enhanced 0xDF and dummy count 8.
- R10: `rd_byte` shows the byte for the current read slot from the cycle after the opcode or the previous slot is taken. It is 0 outside a read. Bytes past a command's length change nothing. Raising `cs_n` before a write is complete discards that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Active-low frame select; high ends a frame |
| byte_valid | input | 1 | One byte slot of the frame is taken this cycle |
| byte_in | input | 8 | Byte received in the slot |
| wr_enable | input | 1 | Write-enable latch state from the sequencer |
| rd_byte | output | 8 | Byte to return in the current read slot |
| seq_clear | output | 1 | One-cycle soft-reset strobe to the sequencer |
| four_byte_dflt | output | 1 | 4-byte address mode value to load on clear |
| ext_addr_dflt | output | 8 | Extended-address value to load on clear |
| dummy_cnt | output | 4 | Dummy count taken from the volatile word |
| cfg_nv | output | 16 | Current nonvolatile word |
| cfg_vol | output | 8 | Current volatile word |
| cfg_enh | output | 8 | Current enhanced word |

## Verification
The bench builds two copies that share one stimulus stream. One copy uses `MFR_ID` 0x20, which reaches the bit-by-bit derivation on both power-on and soft reset. The other uses `MFR_ID` 0xEF, which reaches the branch where reset keeps the volatile words and zeroes the defaults. Both copies keep the default `NV_DEFAULT` of 0x8FFF, so the power-on values and the all-ones field in bits 11:9 are covered. Random nonvolatile values then cover both outcomes of every derived bit.

// File: rtl/cfgrst_pkg.sv
package cfgrst_pkg;
    localparam int BYTE_W = 8;
    localparam int NV_W   = 16;

    localparam logic [BYTE_W-1:0] OP_RST_ARM = 8'h66;
    localparam logic [BYTE_W-1:0] OP_RST_GO  = 8'h99;
    localparam logic [BYTE_W-1:0] OP_NV_WR   = 8'hB1;
    localparam logic [BYTE_W-1:0] OP_NV_RD   = 8'hB5;
    localparam logic [BYTE_W-1:0] OP_VOL_WR  = 8'h81;
    localparam logic [BYTE_W-1:0] OP_VOL_RD  = 8'h85;
    localparam logic [BYTE_W-1:0] OP_ENH_WR  = 8'h61;
    localparam logic [BYTE_W-1:0] OP_ENH_RD  = 8'h65;

    localparam logic [BYTE_W-1:0] DERIVE_MFR = 8'h20;

    typedef enum logic [3:0] {
        ST_OPC,
        ST_NV_LO,
        ST_NV_HI,
        ST_V_WR,
        ST_EV_WR,
        ST_RD_NV_LO,
        ST_RD_NV_HI,
        ST_RD_V,
        ST_RD_EV,
        ST_SKIP
    } frame_st_t;

    // Volatile word rebuilt from the nonvolatile word.
    function automatic logic [BYTE_W-1:0] vol_from_nv(input logic [NV_W-1:0] nv);
        logic [BYTE_W-1:0] r;
        r      = 8'h03;
        r[3]   = ~&nv[11:9];
        r[7:4] = nv[15:12];
        return r;
    endfunction

    // Enhanced word rebuilt from the nonvolatile word.
    function automatic logic [BYTE_W-1:0] enh_from_nv(input logic [NV_W-1:0] nv);
        logic [BYTE_W-1:0] r;
        r    = 8'h1F;
        r[6] = nv[2];
        r[7] = nv[3];
        return r;
    endfunction
endpackage

// File: rtl/cfgrst_frame.sv
module cfgrst_frame
    import cfgrst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              wr_enable,
    output logic              opc_stb,
    output logic [BYTE_W-1:0] opc_code,
    output logic              nv_we,
    output logic [NV_W-1:0]   nv_wdata,
    output logic              vol_we,
    output logic              enh_we,
    output logic [BYTE_W-1:0] cfg_wdata,
    output frame_st_t         st_out
);
    frame_st_t st_q, st_d;
    logic [BYTE_W-1:0] lo_q;
    logic take;

    assign take = byte_valid && !cs_n;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OPC;
        else        st_q <= st_d;
    end

    // Low byte holder for the two-byte nonvolatile write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      lo_q <= '0;
        else if (take && st_q == ST_NV_LO) lo_q <= byte_in;
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d = ST_OPC;
        end else if (byte_valid) begin
            unique case (st_q)
                ST_OPC: begin
                    case (byte_in)
                        OP_NV_WR:  st_d = wr_enable ? ST_NV_LO : ST_SKIP;
                        OP_VOL_WR: st_d = wr_enable ? ST_V_WR  : ST_SKIP;
                        OP_ENH_WR: st_d = wr_enable ? ST_EV_WR : ST_SKIP;
                        OP_NV_RD:  st_d = ST_RD_NV_LO;
                        OP_VOL_RD: st_d = ST_RD_V;
                        OP_ENH_RD: st_d = ST_RD_EV;
                        default:   st_d = ST_SKIP;
                    endcase
                end
                ST_NV_LO:    st_d = ST_NV_HI;
                ST_NV_HI:    st_d = ST_SKIP;
                ST_V_WR:     st_d = ST_SKIP;
                ST_EV_WR:    st_d = ST_SKIP;
                ST_RD_NV_LO: st_d = ST_RD_NV_HI;
                ST_RD_NV_HI: st_d = ST_SKIP;
                ST_RD_V:     st_d = ST_SKIP;
                ST_RD_EV:    st_d = ST_SKIP;
                ST_SKIP:     st_d = ST_SKIP;
                default:     st_d = ST_SKIP;
            endcase
        end
    end

    // Output strobes.
    always_comb begin
        opc_stb   = take && (st_q == ST_OPC);
        opc_code  = byte_in;
        nv_we     = take && (st_q == ST_NV_HI);
        nv_wdata  = {byte_in, lo_q};
        vol_we    = take && (st_q == ST_V_WR);
        enh_we    = take && (st_q == ST_EV_WR);
        cfg_wdata = byte_in;
        st_out    = st_q;
    end

    // R10: a raised select always returns the machine to the opcode slot.
    p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> st_q == ST_OPC);

    // R7: a write state is reachable only with write-enable high at the opcode.
    p_wen_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_stb && !wr_enable) |=> !(st_q inside {ST_NV_LO, ST_V_WR, ST_EV_WR}));
endmodule

// File: rtl/cfgrst_arm.sv
module cfgrst_arm
    import cfgrst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opc_stb,
    input  logic [BYTE_W-1:0] opc_code,
    output logic              do_soft,
    output logic              seq_clear
);
    logic armed_q;
    logic clr_q;

    assign do_soft   = opc_stb && (opc_code == OP_RST_GO) && armed_q;
    assign seq_clear = clr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            if (opc_stb) armed_q <= (opc_code == OP_RST_ARM);
            clr_q <= do_soft;
        end
    end

    // R1: the clear strobe only follows an armed state.
    p_go_needs_arm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> $past(armed_q));

    // R1: any opcode other than the arming one disarms.
    p_disarm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (opc_stb && opc_code != OP_RST_ARM) |=> !armed_q);

    // R2: the clear strobe lasts a single cycle.
    p_clear_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> !clr_q);
endmodule

// File: rtl/cfgrst_regs.sv
module cfgrst_regs
    import cfgrst_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MFR_ID     = 8'h20,
    parameter logic [NV_W-1:0]   NV_DEFAULT = 16'h8FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              do_soft,
    input  logic              nv_we,
    input  logic [NV_W-1:0]   nv_wdata,
    input  logic              vol_we,
    input  logic              enh_we,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [NV_W-1:0]   nv_q,
    output logic [BYTE_W-1:0] vol_q,
    output logic [BYTE_W-1:0] enh_q,
    output logic              four_byte_dflt,
    output logic [BYTE_W-1:0] ext_addr_dflt
);
    localparam bit DERIVE = (MFR_ID == DERIVE_MFR);

    logic [BYTE_W-1:0] vol_soft, enh_soft, vol_por, enh_por;

    generate
        if (DERIVE) begin : g_derive
            localparam logic [BYTE_W-1:0] VOL_POR = vol_from_nv(NV_DEFAULT);
            localparam logic [BYTE_W-1:0] ENH_POR = enh_from_nv(NV_DEFAULT);
            assign vol_soft       = vol_from_nv(nv_q);
            assign enh_soft       = enh_from_nv(nv_q);
            assign vol_por        = VOL_POR;
            assign enh_por        = ENH_POR;
            assign four_byte_dflt = ~nv_q[0];
            assign ext_addr_dflt  = nv_q[1] ? 8'h00 : 8'h03;

            // R3: fixed low bits and copied dummy field after a soft reset.
            p_vol_rebuild_r3: assert property (@(posedge clk) disable iff (!rst_n)
                do_soft |=> (vol_q[1:0] == 2'b11) && (vol_q[7:4] == $past(nv_q[15:12])));

            // R4: fixed low field and the two mode bits after a soft reset.
            p_enh_rebuild_r4: assert property (@(posedge clk) disable iff (!rst_n)
                do_soft |=> (enh_q[4:0] == 5'h1F) && (enh_q[7:6] == $past(nv_q[3:2])));
        end else begin : g_plain
            assign vol_soft       = vol_q;
            assign enh_soft       = enh_q;
            assign vol_por        = '0;
            assign enh_por        = '0;
            assign four_byte_dflt = 1'b0;
            assign ext_addr_dflt  = '0;

            // R8: a soft reset keeps both volatile words.
            p_keep_vol_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (do_soft && !vol_we && !enh_we) |=> $stable(vol_q) && $stable(enh_q));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nv_q  <= NV_DEFAULT;
            vol_q <= vol_por;
            enh_q <= enh_por;
        end else begin
            if (nv_we) nv_q <= nv_wdata;
            if (do_soft) begin
                vol_q <= vol_soft;
                enh_q <= enh_soft;
            end else begin
                if (vol_we) vol_q <= cfg_wdata;
                if (enh_we) enh_q <= cfg_wdata;
            end
        end
    end

    // R6: the nonvolatile word moves only on its own write strobe.
    p_nv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !nv_we |=> $stable(nv_q));
endmodule

// File: rtl/cfgrst_unit.sv
module cfgrst_unit
    import cfgrst_pkg::*;
#(
    parameter logic [7:0]  MFR_ID     = 8'h20,
    parameter logic [15:0] NV_DEFAULT = 16'h8FFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        byte_valid,
    input  logic [7:0]  byte_in,
    input  logic        wr_enable,
    output logic [7:0]  rd_byte,
    output logic        seq_clear,
    output logic        four_byte_dflt,
    output logic [7:0]  ext_addr_dflt,
    output logic [3:0]  dummy_cnt,
    output logic [15:0] cfg_nv,
    output logic [7:0]  cfg_vol,
    output logic [7:0]  cfg_enh
);
    logic              opc_stb, nv_we, vol_we, enh_we, do_soft;
    logic [BYTE_W-1:0] opc_code, cfg_wdata;
    logic [NV_W-1:0]   nv_wdata;
    frame_st_t         st;

    cfgrst_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .wr_enable  (wr_enable),
        .opc_stb    (opc_stb),
        .opc_code   (opc_code),
        .nv_we      (nv_we),
        .nv_wdata   (nv_wdata),
        .vol_we     (vol_we),
        .enh_we     (enh_we),
        .cfg_wdata  (cfg_wdata),
        .st_out     (st)
    );

    cfgrst_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .opc_stb   (opc_stb),
        .opc_code  (opc_code),
        .do_soft   (do_soft),
        .seq_clear (seq_clear)
    );

    cfgrst_regs #(
        .MFR_ID     (MFR_ID),
        .NV_DEFAULT (NV_DEFAULT)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .do_soft        (do_soft),
        .nv_we          (nv_we),
        .nv_wdata       (nv_wdata),
        .vol_we         (vol_we),
        .enh_we         (enh_we),
        .cfg_wdata      (cfg_wdata),
        .nv_q           (cfg_nv),
        .vol_q          (cfg_vol),
        .enh_q          (cfg_enh),
        .four_byte_dflt (four_byte_dflt),
        .ext_addr_dflt  (ext_addr_dflt)
    );

    assign dummy_cnt = cfg_vol[7:4];

    // Read byte for the current slot.
    always_comb begin
        unique case (st)
            ST_RD_NV_LO: rd_byte = cfg_nv[7:0];
            ST_RD_NV_HI: rd_byte = cfg_nv[15:8];
            ST_RD_V:     rd_byte = cfg_vol;
            ST_RD_EV:    rd_byte = cfg_enh;
            default:     rd_byte = 8'h00;
        endcase
    end

    // R10: outside a read state the returned byte is zero.
    p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> rd_byte == 8'h00);
endmodule

// File: tb/cfgrst_unit_tb_top.sv
module cfgrst_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic byte_valid = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic wr_enable = 1'b0;

    logic [7:0]  rd_byte, a_rd_byte;
    logic        seq_clear, a_seq_clear;
    logic        four_byte_dflt, a_four;
    logic [7:0]  ext_addr_dflt, a_ext;
    logic [3:0]  dummy_cnt, a_dummy;
    logic [15:0] cfg_nv, a_nv;
    logic [7:0]  cfg_vol, a_vol, cfg_enh, a_enh;

    int n_tests = 0;
    int n_fail  = 0;
    logic clr_seen;

    // Bench model.
    logic [15:0] nv_m = 16'h8FFF;
    logic [7:0]  v_m, ev_m, av_m, aev_m;
    logic        armed_m = 1'b0;

    always #5 clk = ~clk;

    cfgrst_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid),
        .byte_in(byte_in), .wr_enable(wr_enable), .rd_byte(rd_byte),
        .seq_clear(seq_clear), .four_byte_dflt(four_byte_dflt),
        .ext_addr_dflt(ext_addr_dflt), .dummy_cnt(dummy_cnt),
        .cfg_nv(cfg_nv), .cfg_vol(cfg_vol), .cfg_enh(cfg_enh));

    cfgrst_unit #(.MFR_ID(8'hEF)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_valid(byte_valid),
        .byte_in(byte_in), .wr_enable(wr_enable), .rd_byte(a_rd_byte),
        .seq_clear(a_seq_clear), .four_byte_dflt(a_four),
        .ext_addr_dflt(a_ext), .dummy_cnt(a_dummy),
        .cfg_nv(a_nv), .cfg_vol(a_vol), .cfg_enh(a_enh));

    function automatic logic [7:0] exp_vol(input logic [15:0] nv);
        int r;
        r = 3;
        if (((nv >> 9) & 7) != 7) r = r + 8;
        r = r + (((nv >> 12) & 15) * 16);
        return r[7:0];
    endfunction

    function automatic logic [7:0] exp_enh(input logic [15:0] nv);
        int r;
        r = 31;
        if ((nv & 16'h0004) != 0) r = r + 64;
        if ((nv & 16'h0008) != 0) r = r + 128;
        return r[7:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
        @(negedge clk);
        byte_valid = 1'b0;
        clr_seen   = seq_clear;
    endtask

    // One frame: opcode plus n data bytes, with model update.
    task automatic frame(input logic [7:0] op, input int n,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        logic fire;
        fire = (op == 8'h99) && armed_m;
        @(negedge clk);
        cs_n = 1'b0;
        send_byte(op);
        chk("R2 clear strobe after opcode", {31'd0, clr_seen}, {31'd0, fire});
        @(negedge clk);
        chk("R2 clear strobe single cycle", {31'd0, seq_clear}, 32'd0);
        if (n > 0) send_byte(d0);
        if (n > 1) send_byte(d1);
        if (n > 2) send_byte(d2);
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        if (fire) begin
            v_m  = exp_vol(nv_m);
            ev_m = exp_enh(nv_m);
        end
        armed_m = (op == 8'h66);
        if (wr_enable) begin
            if (op == 8'hB1 && n >= 2) nv_m = {d1, d0};
            if (op == 8'h81 && n >= 1) begin v_m = d0; av_m = d0; end
            if (op == 8'h61 && n >= 1) begin ev_m = d0; aev_m = d0; end
        end
    endtask

    task automatic rd_frame(input logic [7:0] op, input int n,
                            input logic [7:0] e0, input logic [7:0] e1, input string tag);
        @(negedge clk);
        cs_n = 1'b0;
        send_byte(op);
        chk(tag, {24'd0, rd_byte}, {24'd0, e0});
        if (n > 1) begin
            send_byte(8'h00);
            chk(tag, {24'd0, rd_byte}, {24'd0, e1});
        end
        send_byte(8'h00);
        chk("R10 read byte zero after last slot", {24'd0, rd_byte}, 32'd0);
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        armed_m = 1'b0;
    endtask

    task automatic check_all(input string tag);
        chk({"R6 nonvolatile ", tag}, {16'd0, cfg_nv}, {16'd0, nv_m});
        chk({"R3 volatile ", tag}, {24'd0, cfg_vol}, {24'd0, v_m});
        chk({"R4 enhanced ", tag}, {24'd0, cfg_enh}, {24'd0, ev_m});
        chk({"R5 four-byte default ", tag}, {31'd0, four_byte_dflt}, {31'd0, ~nv_m[0]});
        chk({"R5 ext-address default ", tag}, {24'd0, ext_addr_dflt},
            (nv_m[1] == 1'b0) ? 32'd3 : 32'd0);
        chk({"R5 dummy count ", tag}, {28'd0, dummy_cnt}, {28'd0, v_m[7:4]});
        chk({"R8 alt volatile ", tag}, {24'd0, a_vol}, {24'd0, av_m});
        chk({"R8 alt enhanced ", tag}, {24'd0, a_enh}, {24'd0, aev_m});
        chk({"R8 alt defaults ", tag}, {23'd0, a_four, a_ext}, 32'd0);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] rnv;
        logic [7:0]  rv;
        void'($urandom(32'h5EED));
        v_m = 8'h83; ev_m = 8'hDF; av_m = 8'h00; aev_m = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 power-on values.
        chk("R9 power-on nonvolatile", {16'd0, cfg_nv}, 32'h8FFF);
        chk("R9 power-on volatile", {24'd0, cfg_vol}, 32'h83);
        chk("R9 power-on enhanced", {24'd0, cfg_enh}, 32'hDF);
        chk("R9 power-on dummy", {28'd0, dummy_cnt}, 32'd8);
        chk("R2 no strobe at reset", {31'd0, seq_clear}, 32'd0);
        chk("R10 idle read byte", {24'd0, rd_byte}, 32'd0);
        check_all("power-on");

        // R6 read of the nonvolatile word, low byte first.
        rd_frame(8'hB5, 2, 8'hFF, 8'h8F, "R6 nonvolatile read");

        // R7 writes ignored without write-enable.
        wr_enable = 1'b0;
        frame(8'hB1, 2, 8'h12, 8'h34, 8'h00);
        frame(8'h81, 1, 8'h44, 8'h00, 8'h00);
        check_all("R7 write without enable");

        // R6 write, volatile words untouched until reset.
        wr_enable = 1'b1;
        frame(8'hB1, 2, 8'hF0, 8'h51, 8'h00);
        check_all("R6 after nonvolatile write");
        chk("R6 volatile kept until reset", {24'd0, cfg_vol}, 32'h83);

        // R10 partial write discarded.
        frame(8'hB1, 1, 8'h00, 8'h00, 8'h00);
        chk("R10 partial write discarded", {16'd0, cfg_nv}, 32'h51F0);

        // R7 volatile write, with extra bytes ignored (R10).
        frame(8'h81, 3, 8'hA5, 8'h11, 8'h22);
        check_all("R10 extra bytes");
        rd_frame(8'h85, 1, 8'hA5, 8'h00, "R7 volatile read");
        frame(8'h61, 1, 8'h3C, 8'h00, 8'h00);
        rd_frame(8'h65, 1, 8'h3C, 8'h00, "R7 enhanced read");

        // R1 arm then fire in separate frames.
        frame(8'h66, 0, 8'h00, 8'h00, 8'h00);
        frame(8'h99, 0, 8'h00, 8'h00, 8'h00);
        chk("R3 derived volatile 51F0", {24'd0, cfg_vol}, 32'h5B);
        chk("R4 derived enhanced 51F0", {24'd0, cfg_enh}, 32'h1F);
        check_all("R1 armed reset");

        // R1 fire without arming, and arm broken by another opcode.
        frame(8'h81, 1, 8'h77, 8'h00, 8'h00);
        frame(8'h99, 0, 8'h00, 8'h00, 8'h00);
        check_all("R1 unarmed go");
        frame(8'h66, 0, 8'h00, 8'h00, 8'h00);
        rd_frame(8'h85, 1, 8'h77, 8'h00, "R7 volatile read between arm and go");
        frame(8'h99, 0, 8'h00, 8'h00, 8'h00);
        check_all("R1 arm broken");
        frame(8'h66, 0, 8'h00, 8'h00, 8'h00);
        frame(8'h66, 0, 8'h00, 8'h00, 8'h00);
        frame(8'h99, 0, 8'h00, 8'h00, 8'h00);
        check_all("R1 re-armed");

        // Random nonvolatile values and reset paths.
        for (int i = 0; i < 40; i++) begin
            rnv = 16'($urandom);
            rv  = 8'($urandom);
            wr_enable = ($urandom % 5) != 0;
            frame(8'hB1, 2, rnv[7:0], rnv[15:8], 8'h00);
            if ($urandom % 2 == 0) frame(8'h81, 1, rv, 8'h00, 8'h00);
            if ($urandom % 2 == 0) frame(8'h61, 1, ~rv, 8'h00, 8'h00);
            if ($urandom % 4 != 0) frame(8'h66, 0, 8'h00, 8'h00, 8'h00);
            else                   frame(8'h05, 0, 8'h00, 8'h00, 8'h00);
            frame(8'h99, 0, 8'h00, 8'h00, 8'h00);
            check_all("random");
            rd_frame(8'h85, 1, v_m, 8'h00, "R7 random volatile read");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule